// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block carries out a repeat-prefixed string instruction in hardware. It runs one of three element operations: copy (read at the source pointer, write at the destination pointer), fill (write the accumulator at the destination pointer) or load (read at the source pointer into the accumulator). The operation repeats until the element counter reaches zero. The caller captures the counter, both pointers and the accumulator on a start pulse. The block then issues single-element memory requests, one at a time, and keeps the working registers on its outputs.

Work is cut into time slices. Every element adds a fixed cost to a cycle tally. Once the tally passes the slice budget, the slice stops with the resume flag set, so the instruction is issued again with the updated registers. A single-step trap limits a slice to one element. A memory abort stops the slice at once and leaves the registers as they were before the element that faulted. An address-width select picks either full 32-bit counter and pointer arithmetic, or 16-bit arithmetic that wraps and leaves the upper halves untouched.

Top module: `strrep_seq`

## Requirements
- R1: Each committed element lowers the counter by one. A slice that ends without resume or abort leaves the counter at zero (its low 16 bits when `addr_wide`=0).
- R2: The pointers move by the element size: `elem_size` 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes. They move down when `dir_down`=1 and up otherwise. Copy moves both pointers, fill moves only the destination and load moves only the source.
- R3: Each element adds its cost to `tally_out`. Copy costs 3 with `fast_core`=1 and 4 otherwise. Fill and load cost 4 with `fast_core`=1 and 5 otherwise. The tally starts at zero on every start.
- R4: After each element, the slice ends with `resume`=1 if the counter is still nonzero and the tally is greater than the budget. The budget is 100 with `big_budget`=0 and 1000 with `big_budget`=1.
- R5: With `trap`=1 a slice commits exactly one element. It then ends, with `resume`=1 if the counter is still nonzero.
- R6: `resume` is 1 only when the counter is nonzero at the end of a slice. Restarting with the output registers continues the operation to completion.
- R7: `done` is a one-cycle pulse. It rises one cycle after the last element's memory cycle. Copy takes two cycles per element and fill and load take one.
- R8: With `addr_wide`=0, the counter and pointer arithmetic wraps modulo 2^16, bits 31:16 of those registers stay unchanged, and `mem_addr[31:16]` is zero.
- R9: A start whose counter is zero (its low 16 bits when `addr_wide`=0) raises `done` in the next cycle. It makes no memory request, and `resume` stays 0.
- R10: `mem_abort` during a request ends the slice with `aborted`=1 and `resume`=0. Counter, pointers and tally keep their values from before that element.
- R11: A write carries the element in its low bytes and zeros above. Copy writes the element it read from the source, and fill writes the accumulator's low element bytes. Load replaces only the low element bytes of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a slice; sampled while idle |
| op_sel | input | 2 | 0 copy, 1 fill, 2 load (3 acts as load) |
| elem_size | input | 2 | 0 byte, 1 two bytes, 2 four bytes |
| dir_down | input | 1 | 1 decrements the pointers |
| addr_wide | input | 1 | 1 for 32-bit counter/pointers, 0 for 16-bit |
| trap | input | 1 | Single-step: one element per slice |
| fast_core | input | 1 | Selects the lower per-element costs |
| big_budget | input | 1 | Selects the 1000-cycle budget |
| cnt_in | input | 32 | Initial element counter |
| src_in | input | 32 | Initial source pointer |
| dst_in | input | 32 | Initial destination pointer |
| acc_in | input | 32 | Initial accumulator |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Request address |
| mem_size | output | 2 | Element size code of the request |
| mem_wdata | output | 32 | Write data, element in low bytes |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, element in low bytes |
| mem_abort | input | 1 | Request faults this cycle (wins over ack) |
| busy | output | 1 | A slice is issuing requests |
| done | output | 1 | One-cycle end-of-slice pulse |
| resume | output | 1 | Slice ended with work left |
| aborted | output | 1 | Slice ended on a memory abort |
| cnt_out | output | 32 | Working counter |
| src_out | output | 32 | Working source pointer |
| dst_out | output | 32 | Working destination pointer |
| acc_out | output | 32 | Working accumulator |
| tally_out | output | 12 | Cycle cost consumed in this slice |

## Verification
A wrong step amount or direction shows on `mem_addr` at the second element of a slice. It shows on the pointer outputs no later than the `done` pulse. A counter or tally that drifts changes how many requests appear before `done` and whether `resume` is raised. That is visible when the slice ends, and for long budgeted slices it appears as an element count one too high or too low. A state machine that skips or repeats a phase changes the `done` latency and the read/write split that a copy should produce. The sweep covers every operation, size, direction, address width, cost mode and trap setting, with 16-bit pointers that cross the wrap point.

// File: rtl/strrep_pkg.sv
package strrep_pkg;

    parameter int unsigned DATA_W  = 32;
    parameter int unsigned TALLY_W = 12;
    parameter int unsigned COST_W  = 4;

    typedef enum logic [1:0] {
        OP_COPY = 2'd0,
        OP_FILL = 2'd1,
        OP_LOAD = 2'd2
    } str_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        str_op_e             op;
        logic [1:0]          size;
        logic                down;
        logic                wide;
        logic                trap;
        logic                fast;
        logic                big;
        logic [DATA_W-1:0]   cnt;
        logic [DATA_W-1:0]   src;
        logic [DATA_W-1:0]   dst;
        logic [DATA_W-1:0]   acc;
        logic [DATA_W-1:0]   hold;
        logic [TALLY_W-1:0]  tally;
        logic                resume;
        logic                aborted;
    } seq_state_t;

    function automatic logic [2:0] elem_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] elem_mask(input logic [1:0] code);
        case (code)
            2'd0:    return DATA_W'(32'h0000_00FF);
            2'd1:    return DATA_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/strrep_step.sv
module strrep_step #(
    parameter int unsigned DW       = 32,
    parameter int unsigned NARROW_W = 16,
    parameter int unsigned AMT_W    = 3
) (
    input  logic [DW-1:0]    ptr_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             down_i,
    input  logic             wide_i,
    output logic [DW-1:0]    ptr_o
);
    localparam int unsigned HI_W = DW - NARROW_W;

    logic [DW-1:0]       amt_ext;
    logic [DW-1:0]       full_res;
    logic [NARROW_W-1:0] narrow_res;

    always_comb begin
        amt_ext    = DW'(amt_i);
        full_res   = down_i ? (ptr_i - amt_ext) : (ptr_i + amt_ext);
        narrow_res = down_i ? (ptr_i[NARROW_W-1:0] - amt_ext[NARROW_W-1:0])
                            : (ptr_i[NARROW_W-1:0] + amt_ext[NARROW_W-1:0]);
        ptr_o      = wide_i ? full_res : {ptr_i[DW-1:DW-HI_W], narrow_res};
    end
endmodule

// File: rtl/strrep_budget.sv
module strrep_budget
    import strrep_pkg::*;
#(
    parameter int unsigned COPY_FAST = 3,
    parameter int unsigned COPY_SLOW = 4,
    parameter int unsigned XFER_FAST = 4,
    parameter int unsigned XFER_SLOW = 5,
    parameter int unsigned LIMIT_STD = 100,
    parameter int unsigned LIMIT_EXT = 1000
) (
    input  str_op_e              op_i,
    input  logic                 fast_i,
    input  logic                 ext_i,
    output logic [COST_W-1:0]    cost_o,
    output logic [TALLY_W-1:0]   limit_o
);
    always_comb begin
        if (op_i == OP_COPY) begin
            cost_o = fast_i ? COST_W'(COPY_FAST) : COST_W'(COPY_SLOW);
        end else begin
            cost_o = fast_i ? COST_W'(XFER_FAST) : COST_W'(XFER_SLOW);
        end
        limit_o = ext_i ? TALLY_W'(LIMIT_EXT) : TALLY_W'(LIMIT_STD);
    end
endmodule

// File: rtl/strrep_seq.sv
module strrep_seq
    import strrep_pkg::*;
#(
    parameter int unsigned NARROW_W  = 16,
    parameter int unsigned LIMIT_STD = 100,
    parameter int unsigned LIMIT_EXT = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          op_sel,
    input  logic [1:0]          elem_size,
    input  logic                dir_down,
    input  logic                addr_wide,
    input  logic                trap,
    input  logic                fast_core,
    input  logic                big_budget,
    input  logic [DATA_W-1:0]   cnt_in,
    input  logic [DATA_W-1:0]   src_in,
    input  logic [DATA_W-1:0]   dst_in,
    input  logic [DATA_W-1:0]   acc_in,
    output logic                mem_req,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_addr,
    output logic [1:0]          mem_size,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_abort,
    output logic                busy,
    output logic                done,
    output logic                resume,
    output logic                aborted,
    output logic [DATA_W-1:0]   cnt_out,
    output logic [DATA_W-1:0]   src_out,
    output logic [DATA_W-1:0]   dst_out,
    output logic [DATA_W-1:0]   acc_out,
    output logic [TALLY_W-1:0]  tally_out
);
    localparam int unsigned N_STEP = 3;   // counter, source, destination
    localparam int unsigned HI_W   = DATA_W - NARROW_W;

    seq_state_t q, d;

    // shared arithmetic
    logic [DATA_W-1:0] step_in  [N_STEP];
    logic [2:0]        step_amt [N_STEP];
    logic              step_dn  [N_STEP];
    logic [DATA_W-1:0] step_out [N_STEP];

    assign step_in[0]  = q.cnt;
    assign step_amt[0] = 3'd1;
    assign step_dn[0]  = 1'b1;
    assign step_in[1]  = q.src;
    assign step_amt[1] = elem_bytes(q.size);
    assign step_dn[1]  = q.down;
    assign step_in[2]  = q.dst;
    assign step_amt[2] = elem_bytes(q.size);
    assign step_dn[2]  = q.down;

    for (genvar gi = 0; gi < N_STEP; gi++) begin : g_step
        strrep_step #(
            .DW      (DATA_W),
            .NARROW_W(NARROW_W),
            .AMT_W   (3)
        ) u_step (
            .ptr_i (step_in[gi]),
            .amt_i (step_amt[gi]),
            .down_i(step_dn[gi]),
            .wide_i(q.wide),
            .ptr_o (step_out[gi])
        );
    end

    logic [COST_W-1:0]  elem_cost;
    logic [TALLY_W-1:0] slice_limit;

    strrep_budget #(
        .LIMIT_STD(LIMIT_STD),
        .LIMIT_EXT(LIMIT_EXT)
    ) u_budget (
        .op_i   (q.op),
        .fast_i (q.fast),
        .ext_i  (q.big),
        .cost_o (elem_cost),
        .limit_o(slice_limit)
    );

    // derived views of the working registers
    str_op_e            op_in;
    logic               start_zero;
    logic               cnt_next_zero;
    logic [DATA_W-1:0]  cur_mask;
    logic [DATA_W-1:0]  src_vis;
    logic [DATA_W-1:0]  dst_vis;
    logic [TALLY_W-1:0] tally_sum;
    logic               commit;

    always_comb begin
        op_in         = (op_sel == 2'd3) ? OP_LOAD : str_op_e'(op_sel);
        start_zero    = addr_wide ? (cnt_in == '0) : (cnt_in[NARROW_W-1:0] == '0);
        cnt_next_zero = q.wide ? (step_out[0] == '0) : (step_out[0][NARROW_W-1:0] == '0);
        cur_mask      = elem_mask(q.size);
        src_vis       = q.wide ? q.src : {{HI_W{1'b0}}, q.src[NARROW_W-1:0]};
        dst_vis       = q.wide ? q.dst : {{HI_W{1'b0}}, q.dst[NARROW_W-1:0]};
        tally_sum     = q.tally + TALLY_W'(elem_cost);
    end

    // next-state process
    always_comb begin
        d         = q;
        commit    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.op      = op_in;
                    d.size    = elem_size;
                    d.down    = dir_down;
                    d.wide    = addr_wide;
                    d.trap    = trap;
                    d.fast    = fast_core;
                    d.big     = big_budget;
                    d.cnt     = cnt_in;
                    d.src     = src_in;
                    d.dst     = dst_in;
                    d.acc     = acc_in;
                    d.tally   = '0;
                    d.resume  = 1'b0;
                    d.aborted = 1'b0;
                    if (start_zero) begin
                        d.phase = PH_DONE;
                    end else if (op_in == OP_FILL) begin
                        d.phase = PH_WRITE;
                    end else begin
                        d.phase = PH_READ;
                    end
                end
            end

            PH_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_vis;
                if (mem_abort) begin
                    d.aborted = 1'b1;
                    d.phase   = PH_DONE;
                end else if (mem_ack) begin
                    if (q.op == OP_COPY) begin
                        d.hold  = mem_rdata & cur_mask;
                        d.phase = PH_WRITE;
                    end else begin
                        d.acc  = (q.acc & ~cur_mask) | (mem_rdata & cur_mask);
                        commit = 1'b1;
                    end
                end
            end

            PH_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_vis;
                mem_wdata = ((q.op == OP_COPY) ? q.hold : q.acc) & cur_mask;
                if (mem_abort) begin
                    d.aborted = 1'b1;
                    d.phase   = PH_DONE;
                end else if (mem_ack) begin
                    commit = 1'b1;
                end
            end

            default: begin
                d.phase = PH_IDLE;
            end
        endcase

        if (commit) begin
            d.cnt   = step_out[0];
            d.tally = tally_sum;
            if (q.op != OP_FILL) d.src = step_out[1];
            if (q.op != OP_LOAD) d.dst = step_out[2];
            if (cnt_next_zero) begin
                d.phase  = PH_DONE;
                d.resume = 1'b0;
            end else if (q.trap || (tally_sum > slice_limit)) begin
                d.phase  = PH_DONE;
                d.resume = 1'b1;
            end else if (q.op == OP_FILL) begin
                d.phase = PH_WRITE;
            end else begin
                d.phase = PH_READ;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_size  = q.size;
    assign busy      = (q.phase == PH_READ) || (q.phase == PH_WRITE);
    assign done      = (q.phase == PH_DONE);
    assign resume    = q.resume;
    assign aborted   = q.aborted;
    assign cnt_out   = q.cnt;
    assign src_out   = q.src;
    assign dst_out   = q.dst;
    assign acc_out   = q.acc;
    assign tally_out = q.tally;

    // views for the bound checker
    logic wide_q;
    logic load_q;
    assign wide_q = q.wide;
    assign load_q = (q.op == OP_LOAD);

endmodule

// File: rtl/strrep_seq_props.sv
module strrep_seq_props (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        addr_wide,
    input logic [31:0] cnt_in,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic        mem_abort,
    input logic        busy,
    input logic        done,
    input logic        resume,
    input logic        aborted,
    input logic [31:0] cnt_out,
    input logic        wide_q,
    input logic        load_q
);
    logic cnt_live;
    assign cnt_live = wide_q ? (cnt_out != 32'd0) : (cnt_out[15:0] != 16'd0);

    // R1: each committed element lowers the counter by one
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_abort && (mem_we || load_q))
        |=> (cnt_out[15:0] == $past(cnt_out[15:0]) - 16'd1));

    // R1: a clean finish leaves no work
    a_r1_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !resume && !aborted) |-> !cnt_live);

    // R6: resume only with work left
    a_r6_resume_live: assert property (@(posedge clk) disable iff (!rst_n)
        (done && resume) |-> cnt_live);

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: requests only while a slice is active
    a_r7_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R8: upper counter half untouched in narrow mode
    a_r8_upper_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wide_q) |=> (cnt_out[31:16] == $past(cnt_out[31:16])));

    // R9: zero-count start finishes next cycle with no traffic
    a_r9_zero_quick: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done &&
         (addr_wide ? (cnt_in == 32'd0) : (cnt_in[15:0] == 16'd0)))
        |=> (done && !mem_req && !resume));

    // R10: abort ends the slice and freezes the counter
    a_r10_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_abort) |=> (done && aborted && !resume && $stable(cnt_out)));
endmodule

bind strrep_seq strrep_seq_props u_props (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .addr_wide(addr_wide),
    .cnt_in   (cnt_in),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_abort(mem_abort),
    .busy     (busy),
    .done     (done),
    .resume   (resume),
    .aborted  (aborted),
    .cnt_out  (cnt_out),
    .wide_q   (wide_q),
    .load_q   (load_q)
);

// File: tb/strrep_seq_bench.sv
module strrep_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [1:0]  elem_size = 2'd0;
    logic        dir_down = 1'b0;
    logic        addr_wide = 1'b1;
    logic        trap = 1'b0;
    logic        fast_core = 1'b0;
    logic        big_budget = 1'b0;
    logic [31:0] cnt_in = '0;
    logic [31:0] src_in = '0;
    logic [31:0] dst_in = '0;
    logic [31:0] acc_in = '0;
    logic        mem_req, mem_we, mem_ack, mem_abort;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        busy, done, resume, aborted;
    logic [31:0] cnt_out, src_out, dst_out, acc_out;
    logic [11:0] tally_out;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic        abort_en = 1'b0;
    logic [31:0] abort_addr = '0;
    logic        abort_hit;

    int          rd_n = 0;
    int          wr_n = 0;
    int          hi_bad = 0;
    logic [31:0] last_wa = '0;
    logic [31:0] last_wd = '0;
    logic        chk_narrow = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [7:0] pbyte(input logic [31:0] x);
        return x[7:0] ^ x[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {pbyte(a + 32'd3), pbyte(a + 32'd2), pbyte(a + 32'd1), pbyte(a)};
    endfunction

    function automatic logic [31:0] mv(input logic [31:0] p, input int delta,
                                       input logic dn, input logic wd);
        logic [31:0] full;
        logic [15:0] nar;
        full = dn ? (p - 32'(delta)) : (p + 32'(delta));
        nar  = dn ? (p[15:0] - 16'(delta)) : (p[15:0] + 16'(delta));
        return wd ? full : {p[31:16], nar};
    endfunction

    function automatic logic [31:0] vis(input logic [31:0] p, input logic wd);
        return wd ? p : {16'h0, p[15:0]};
    endfunction

    function automatic logic [31:0] mask_of(input int sz);
        return (sz == 0) ? 32'h0000_00FF : (sz == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    assign abort_hit = abort_en && mem_req && (mem_addr == abort_addr);
    assign mem_ack   = mem_req && !abort_hit;
    assign mem_abort = mem_req && abort_hit;
    assign mem_rdata = pat(mem_addr);

    strrep_seq u_strrep_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .elem_size(elem_size), .dir_down(dir_down), .addr_wide(addr_wide),
        .trap(trap), .fast_core(fast_core), .big_budget(big_budget),
        .cnt_in(cnt_in), .src_in(src_in), .dst_in(dst_in), .acc_in(acc_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_abort(mem_abort), .busy(busy),
        .done(done), .resume(resume), .aborted(aborted), .cnt_out(cnt_out),
        .src_out(src_out), .dst_out(dst_out), .acc_out(acc_out),
        .tally_out(tally_out)
    );

    always @(negedge clk) begin
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                wr_n    = wr_n + 1;
                last_wa = mem_addr;
                last_wd = mem_wdata;
            end else begin
                rd_n = rd_n + 1;
            end
            if (chk_narrow && (mem_addr[31:16] != 16'h0)) hi_bad = hi_bad + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one slice: drive, wait for done, compare against arithmetic expectation
    task automatic run_slice(input int op, input int sz, input logic dn, input logic wd,
                             input logic tr, input logic fs, input logic bg,
                             input logic [31:0] c0, input logic [31:0] s0,
                             input logic [31:0] d0, input logic [31:0] a0);
        int sb, cost, lim, n, e, lat, exp_lat;
        logic [31:0] msk, exp_cnt, exp_src, exp_dst, exp_acc, lsrc, ldst;
        sb   = 1 << sz;
        cost = (op == 0) ? (fs ? 3 : 4) : (fs ? 4 : 5);
        lim  = (bg ? 1000 : 100) / cost + 1;
        n    = wd ? int'(c0) : int'(c0[15:0]);
        if (n == 0)      e = 0;
        else if (tr)     e = 1;
        else             e = (n < lim) ? n : lim;
        msk  = mask_of(sz);

        @(negedge clk);
        op_sel = 2'(op); elem_size = 2'(sz); dir_down = dn; addr_wide = wd;
        trap = tr; fast_core = fs; big_budget = bg;
        cnt_in = c0; src_in = s0; dst_in = d0; acc_in = a0;
        rd_n = 0; wr_n = 0; hi_bad = 0; chk_narrow = !wd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 5000) begin
            @(negedge clk);
            lat = lat + 1;
        end

        exp_cnt = wd ? (c0 - 32'(e)) : {c0[31:16], c0[15:0] - 16'(e)};
        exp_src = (op == 1) ? s0 : mv(s0, e * sb, dn, wd);
        exp_dst = (op == 2) ? d0 : mv(d0, e * sb, dn, wd);
        lsrc    = vis(mv(s0, (e - 1) * sb, dn, wd), wd);
        ldst    = vis(mv(d0, (e - 1) * sb, dn, wd), wd);
        exp_acc = (op == 2 && e > 0) ? ((a0 & ~msk) | (pat(lsrc) & msk)) : a0;
        exp_lat = (e == 0) ? 1 : e * ((op == 0) ? 2 : 1) + 1;

        chk("R1 counter", cnt_out, exp_cnt);
        chk("R2 source pointer", src_out, exp_src);
        chk("R2 destination pointer", dst_out, exp_dst);
        chk("R3 tally", 32'(tally_out), 32'(e * cost));
        if (tr) begin
            chk("R5 resume", 32'(resume), 32'((n - e) != 0));
            chk("R5 elements", 32'(rd_n + wr_n), 32'(e * ((op == 0) ? 2 : 1)));
        end else begin
            chk("R4 resume", 32'(resume), 32'((n - e) != 0));
            chk("R4 elements", 32'(rd_n + wr_n), 32'(e * ((op == 0) ? 2 : 1)));
        end
        chk("R7 done latency", 32'(lat), 32'(exp_lat));
        chk("R10 no abort", 32'(aborted), 32'd0);
        chk("R11 accumulator", acc_out, exp_acc);
        if (e > 0 && op != 2) begin
            chk("R11 last write addr", last_wa, ldst);
            chk("R11 last write data", last_wd,
                (op == 0) ? (pat(lsrc) & msk) : (a0 & msk));
        end
        if (!wd) chk("R8 upper address zero", 32'(hi_bad), 32'd0);
        if (n == 0) chk("R9 zero count no traffic", 32'(rd_n + wr_n), 32'd0);
        @(negedge clk);
        chk("R7 done pulse low", 32'(done), 32'd0);
    endtask

    initial begin : watchdog
        while (cyc < 190000) begin
            @(posedge clk);
            cyc = cyc + 1;
        end
        bad   = bad + 1;
        total = total + 1;
        $display("FAIL watchdog act=%0d exp=<190000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int slices;
        logic [31:0] c, s, dd, a;
        repeat (3) @(negedge clk);
        chk("R7 reset done", 32'(done), 32'd0);
        chk("R7 reset busy", 32'(busy), 32'd0);
        chk("R1 reset counter", cnt_out, 32'd0);
        rst_n = 1'b1;

        // sweep every mode combination at small counts
        for (int op = 0; op < 3; op++)
        for (int sz = 0; sz < 3; sz++)
        for (int dn = 0; dn < 2; dn++)
        for (int wd = 0; wd < 2; wd++)
        for (int tr = 0; tr < 2; tr++)
        for (int fs = 0; fs < 2; fs++)
        for (int ci = 0; ci < 4; ci++) begin
            int nn;
            nn = (ci == 0) ? 0 : (ci == 1) ? 1 : (ci == 2) ? 5 : 40;
            run_slice(op, sz, 1'(dn), 1'(wd), 1'(tr), 1'(fs), 1'b0,
                      wd ? 32'(nn) : (32'h0003_0000 | 32'(nn)),
                      wd ? 32'h0000_FFF8 : 32'h9ABC_FFF8,
                      wd ? 32'h0002_0010 : 32'h4321_0006,
                      32'hC3A5_96E1);
        end

        // extended budget (R4)
        for (int op = 0; op < 3; op++)
        for (int fs = 0; fs < 2; fs++)
            run_slice(op, 2, 1'b0, 1'b1, 1'b0, 1'(fs), 1'b1,
                      32'd400, 32'h0010_0000, 32'h0020_0000, 32'h1234_5678);

        // R6: restart from the outputs until the copy completes
        c = 32'd100; s = 32'h0000_0400; dd = 32'h0000_0800; a = 32'h0;
        slices = 0;
        do begin
            run_slice(0, 1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, c, s, dd, a);
            c = cnt_out; s = src_out; dd = dst_out; a = acc_out;
            slices = slices + 1;
        end while (resume && slices < 10);
        chk("R6 slices to finish", 32'(slices), 32'd3);
        chk("R6 final counter", cnt_out, 32'd0);
        chk("R6 final source", src_out, 32'h0000_0400 + 32'd200);

        // R10: abort on the third element's write
        @(negedge clk);
        abort_en = 1'b1; abort_addr = 32'h0000_0204;
        op_sel = 2'd0; elem_size = 2'd1; dir_down = 1'b0; addr_wide = 1'b1;
        trap = 1'b0; fast_core = 1'b1; big_budget = 1'b0;
        cnt_in = 32'd5; src_in = 32'h100; dst_in = 32'h200; acc_in = 32'h0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk("R10 aborted", 32'(aborted), 32'd1);
        chk("R10 resume", 32'(resume), 32'd0);
        chk("R10 counter", cnt_out, 32'd3);
        chk("R10 source", src_out, 32'h104);
        chk("R10 destination", dst_out, 32'h204);
        chk("R10 tally", 32'(tally_out), 32'd6);
        @(negedge clk);
        abort_en = 1'b0;

        // R8: narrow counter with upper bits set and a wrapping pointer
        run_slice(2, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
                  32'h0001_0002, 32'hABCD_FFFF, 32'h0, 32'h0);
        chk("R8 wrapped source", src_out, 32'hABCD_0001);
        chk("R8 counter upper kept", cnt_out, 32'h0001_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule